// File: doc/BRIEF.md
# Quasi-Bidirectional Parallel I/O Port

This block is a general-purpose byte-wide I/O port in which every pin is controlled by a single storage bit and has no direction register. A zero in a pin's storage bit turns on a strong pull-down, so the pin goes low. A one turns the pull-down off and releases the pin. A released pin is then set by an outside driver, by a weak internal pull-up, or by an external resistor. To use a pin as an input, software writes a one to it and then reads it.

The CPU side has a synchronous register interface. A write strobe loads the storage bits. Two read strobes load a registered read bus. One returns the level sensed at the pins, after a two-flop synchronizer. The other returns the stored bits, whatever the pins are doing.

The pin side is modelled as resolved signals rather than a tri-state net. The external world is given as three inputs per pin: a drive-enable, a driven level and an external pull-up. The block reports three outputs per pin: whether its pull-down is on, the resolved pin level, and whether the pin is floating. A parameter selects the variant without the internal pull-up. Bit i of every bus belongs to pin i, with bit 0 as the least significant bit.

Top module: `qbio_port`

## Requirements
- R1: While `rst` is high at a clock edge, every storage bit becomes 1, `rd_data` becomes 0 and all synchronizer stages become 1. After reset, `pin_pd_on` is 0 for every pin and a latch read returns 8'hFF.
- R2: A clock edge with `wr_en` high loads `wr_data` into the storage bits, bit i to pin i. From then on, `pin_pd_on[i]` is 1 exactly when storage bit i is 0.
- R3: A clock edge with `rd_pin_en` high and `rd_latch_en` low loads `rd_data` with the pin levels. Those levels are sampled through a two-flop synchronizer, so a level held for at least two edges before the strobe edge is returned.
- R4: A clock edge with `rd_latch_en` high loads `rd_data` with the storage bits, whatever the pin levels are.
- R5: A pin whose storage bit is 0 resolves to level 0, even when an external driver drives it high.
- R6: A pin whose storage bit is 1 takes the external level when `ext_oe[i]` is 1. Otherwise it resolves to 1 if the internal pull-up is present (`HAS_PULLUP`=1) or `ext_pu[i]` is 1.
- R7: With `HAS_PULLUP`=0, a pin whose storage bit is 1 and which has neither external drive nor external pull-up sets `pin_float[i]` to 1 and reports level 0. Otherwise `pin_float[i]` is 0.
- R8: When a write and a read strobe share a clock edge, the read returns the value from before that write.
- R9: When `rd_pin_en` and `rd_latch_en` are both high, the latch read takes priority.
- R10: `rd_data` keeps its value at every edge with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the storage bits |
| wr_data | input | WIDTH | Value to store |
| rd_pin_en | input | 1 | Read-pin strobe |
| rd_latch_en | input | 1 | Read-storage strobe |
| rd_data | output | WIDTH | Registered read bus |
| ext_oe | input | WIDTH | External driver enable, per pin |
| ext_lvl | input | WIDTH | Level driven by the external driver |
| ext_pu | input | WIDTH | External pull-up present, per pin |
| pin_pd_on | output | WIDTH | Internal pull-down is on |
| pin_level | output | WIDTH | Resolved pin level |
| pin_float | output | WIDTH | Pin is undriven and unpulled |

## Verification
A corrupted storage bit shows at once on `pin_pd_on` and `pin_level`, in the cycle after the write, and on `rd_data` one edge after a latch read. A fault in the synchronizer or the read mux shows only on pin reads. Such a fault appears as a level that is stale, or that comes from the wrong source, three edges after the pins change. The bench therefore sweeps all 256 stored values and a wide spread of external drive patterns. It compares both read paths and the pin outputs against an arithmetic resolution model, for both pull-up variants.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

   typedef struct packed {
      logic level;
      logic floating;
   } pad_res_t;

   // Strong pull-down wins, then an external driver, then any pull-up.
   function automatic pad_res_t resolve_pad(input logic pull_down,
                                            input logic drv_en,
                                            input logic drv_lvl,
                                            input logic pull_up);
      pad_res_t r;
      if (pull_down) begin
         r.level    = 1'b0;
         r.floating = 1'b0;
      end else if (drv_en) begin
         r.level    = drv_lvl;
         r.floating = 1'b0;
      end else begin
         r.level    = pull_up;
         r.floating = ~pull_up;
      end
      return r;
   endfunction

endpackage

// File: rtl/qbio_latch.sv
module qbio_latch #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] latch_q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("qbio_latch: WIDTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst)        latch_q <= '1;
      else if (wr_en) latch_q <= wr_data;
   end

   AST_RESET_RELEASES: assert property (@(posedge clk)
      rst |=> (latch_q == {WIDTH{1'b1}}));                         // R1

   AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (latch_q == $past(wr_data)));                      // R2

   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(latch_q));                                // R2

endmodule

// File: rtl/qbio_pad.sv
module qbio_pad
   import qbio_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit HAS_PULLUP = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] ext_oe,
   input  logic [WIDTH-1:0] ext_lvl,
   input  logic [WIDTH-1:0] ext_pu,
   output logic [WIDTH-1:0] pd_on,
   output logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] floating
);

   logic [WIDTH-1:0] weak_hi;

   if (HAS_PULLUP) begin : g_pullup
      assign weak_hi = '1;
   end else begin : g_no_pullup
      assign weak_hi = '0;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      pad_res_t res;
      assign pd_on[i]    = ~latch_q[i];
      assign res         = resolve_pad(pd_on[i], ext_oe[i], ext_lvl[i],
                                       weak_hi[i] | ext_pu[i]);
      assign level[i]    = res.level;
      assign floating[i] = res.floating;

      AST_PD_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
         !latch_q[i] |-> !level[i]);                               // R5

      AST_DRIVE_PASSES: assert property (@(posedge clk) disable iff (rst)
         (latch_q[i] && ext_oe[i]) |-> (level[i] == ext_lvl[i]));  // R6

      AST_FLOAT_IS_LOW: assert property (@(posedge clk) disable iff (rst)
         floating[i] |-> (!level[i] && latch_q[i] && !ext_pu[i])); // R7
   end

endmodule

// File: rtl/qbio_sync.sv
module qbio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qbio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst)         stage[s] <= '1;
         else if (s == 0) stage[s] <= d;
         else             stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage[STAGES-1];

   AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (stage[0] == $past(d)));                            // R3

   AST_SYNC_LAST: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (q == $past(stage[STAGES-2])));                     // R3

endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_PULLUP  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_pin_en,
   input  logic             rd_latch_en,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] ext_oe,
   input  logic [WIDTH-1:0] ext_lvl,
   input  logic [WIDTH-1:0] ext_pu,
   output logic [WIDTH-1:0] pin_pd_on,
   output logic [WIDTH-1:0] pin_level,
   output logic [WIDTH-1:0] pin_float
);

   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("qbio_port: WIDTH out of range 1..64");
   end

   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] pin_sync;

   qbio_latch #(.WIDTH(WIDTH)) u_latch (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .latch_q (latch_q)
   );

   qbio_pad #(.WIDTH(WIDTH), .HAS_PULLUP(HAS_PULLUP)) u_pad (
      .clk      (clk),
      .rst      (rst),
      .latch_q  (latch_q),
      .ext_oe   (ext_oe),
      .ext_lvl  (ext_lvl),
      .ext_pu   (ext_pu),
      .pd_on    (pin_pd_on),
      .level    (pin_level),
      .floating (pin_float)
   );

   qbio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_level),
      .q   (pin_sync)
   );

   // Latch read has priority; nonblocking update gives the pre-write value.
   always_ff @(posedge clk) begin
      if (rst)              rd_data <= '0;
      else if (rd_latch_en) rd_data <= latch_q;
      else if (rd_pin_en)   rd_data <= pin_sync;
   end

   AST_RESET_CLEARS_BUS: assert property (@(posedge clk)
      rst |=> (rd_data == '0));                                    // R1

   AST_READ_PIN: assert property (@(posedge clk) disable iff (rst)
      (rd_pin_en && !rd_latch_en) |=> (rd_data == $past(pin_sync))); // R3

   AST_READ_LATCH: assert property (@(posedge clk) disable iff (rst)
      rd_latch_en |=> (rd_data == $past(latch_q)));                // R4

   AST_BUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!rd_pin_en && !rd_latch_en) |=> $stable(rd_data));          // R10

endmodule

// File: tb/tb_qbio_port.sv
module tb_qbio_port;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         wr_en = 1'b0, rd_pin_en = 1'b0, rd_latch_en = 1'b0;
   logic [W-1:0] wr_data = '0, ext_oe = '0, ext_lvl = '0, ext_pu = '0;
   logic [W-1:0] rd_data, pd_on, level, flt;
   logic [W-1:0] rd_data_np, pd_on_np, level_np, flt_np;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   qbio_port #(.WIDTH(W), .HAS_PULLUP(1'b1)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .rd_data(rd_data),
      .ext_oe(ext_oe), .ext_lvl(ext_lvl), .ext_pu(ext_pu),
      .pin_pd_on(pd_on), .pin_level(level), .pin_float(flt));

   qbio_port #(.WIDTH(W), .HAS_PULLUP(1'b0)) dut_np (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .rd_data(rd_data_np),
      .ext_oe(ext_oe), .ext_lvl(ext_lvl), .ext_pu(ext_pu),
      .pin_pd_on(pd_on_np), .pin_level(level_np), .pin_float(flt_np));

   function automatic logic [W-1:0] exp_level(input logic [W-1:0] lat, oe, lv, pu,
                                              input bit hp);
      return lat & ((oe & lv) | (~oe & (pu | {W{hp}})));
   endfunction

   function automatic logic [W-1:0] exp_float(input logic [W-1:0] lat, oe, pu,
                                              input bit hp);
      return lat & ~oe & ~pu & {W{~hp}};
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic do_write(input logic [W-1:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_read(input bit pin_sel);
      @(negedge clk);
      if (pin_sel) rd_pin_en = 1'b1; else rd_latch_en = 1'b1;
      @(negedge clk); rd_pin_en = 1'b0; rd_latch_en = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 pd_on in reset", pd_on, 8'h00);
      chk("R1 rd_data in reset", rd_data, 8'h00);
      chk("R1 level released", level, 8'hFF);
      chk("R1 np float released", flt_np, 8'hFF);
      rst = 1'b0;
      do_read(1'b0);
      chk("R1 latch reads FF", rd_data, 8'hFF);

      // R2 R3 R4 R6 R7: all stored values, pins undriven
      for (int v = 0; v < 256; v++) begin
         logic [W-1:0] b;
         b = v[W-1:0];
         do_write(b);
         chk("R2 pd_on", pd_on, ~b);
         chk("R6 level pullup", level, b);
         chk("R7 np level", level_np, 8'h00);
         chk("R7 np float", flt_np, b);
         do_read(1'b0);
         chk("R4 latch read", rd_data, b);
         chk("R4 np latch read", rd_data_np, b);
         settle();
         do_read(1'b1);
         chk("R3 pin read", rd_data, b);
         chk("R3 np pin read", rd_data_np, 8'h00);
      end

      // R3 R4 R5 R6 R7: mixed external drive patterns
      for (int k = 0; k < 256; k++) begin
         logic [W-1:0] lat, oe, lv, pu;
         lat = W'(k * 37 + 3);
         oe  = ~{k[3:0], k[7:4]};
         lv  = k[W-1:0];
         pu  = k[W-1:0] ^ 8'h33;
         ext_oe = oe; ext_lvl = lv; ext_pu = pu;
         do_write(lat);
         chk("R5 R6 level", level, exp_level(lat, oe, lv, pu, 1'b1));
         chk("R5 R7 np level", level_np, exp_level(lat, oe, lv, pu, 1'b0));
         chk("R7 float", flt, exp_float(lat, oe, pu, 1'b1));
         chk("R7 np float", flt_np, exp_float(lat, oe, pu, 1'b0));
         settle();
         do_read(1'b1);
         chk("R3 pin read driven", rd_data, exp_level(lat, oe, lv, pu, 1'b1));
         chk("R3 np pin read driven", rd_data_np, exp_level(lat, oe, lv, pu, 1'b0));
         do_read(1'b0);
         chk("R4 latch read driven", rd_data, lat);
      end

      // R5: strong pull-down against external high
      ext_oe = 8'hFF; ext_lvl = 8'hFF; ext_pu = 8'h00;
      do_write(8'h00);
      chk("R5 contention low", level, 8'h00);

      // R9: both strobes, latch wins over differing pin level
      ext_lvl = 8'h0F;
      do_write(8'hFF);
      settle();
      @(negedge clk); rd_pin_en = 1'b1; rd_latch_en = 1'b1;
      @(negedge clk); rd_pin_en = 1'b0; rd_latch_en = 1'b0;
      chk("R9 latch priority", rd_data, 8'hFF);

      // R8: write and latch read on the same edge
      do_write(8'h3C);
      @(negedge clk); wr_en = 1'b1; wr_data = 8'hC3; rd_latch_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; rd_latch_en = 1'b0;
      chk("R8 read before write", rd_data, 8'h3C);
      do_read(1'b0);
      chk("R8 new value after", rd_data, 8'hC3);

      // R8: write and pin read on the same edge (pins settled for 8'hFF first)
      ext_oe = 8'h00; ext_pu = 8'h00;
      do_write(8'hFF);
      settle();
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h00; rd_pin_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; rd_pin_en = 1'b0;
      chk("R8 pin read before write", rd_data, 8'hFF);

      // R10: no strobe, pins and latch change, bus holds
      do_write(8'h5A);
      ext_oe = 8'hFF; ext_lvl = 8'h81;
      repeat (5) @(negedge clk);
      chk("R10 bus holds", rd_data, 8'hFF);

      // R1: mid-run reset releases all pins again
      do_write(8'h00);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R1 pd off after reset", pd_on, 8'h00);
      chk("R1 bus cleared", rd_data, 8'h00);
      do_read(1'b0);
      chk("R1 latch FF after reset", rd_data, 8'hFF);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule